// File: doc/BRIEF.md
# In-Order Load Instruction Tracker with Split Issue and Commit Stages

This block keeps vector load instructions in order between the cycle they are accepted and the cycle their last byte has been written back. It has one write position and two read positions. The accept position takes new requests. The issue position follows the instruction whose memory data is still arriving. The commit position follows the oldest instruction, whose data is still draining to the register file. Each position moves on its own and wraps around the same small ring of entries. Because of this, three instructions at three different life stages can make progress in the same cycle.

Each entry holds an identifier and a byte total. The total is the element count shifted left by the element-size code. The issue stage and the commit stage each run a countdown of the bytes left for the entry they face. Neighbouring logic lowers a countdown by sending a pulse together with a byte amount. When the issue countdown reaches zero, the entry moves from pending to in flight. When the commit countdown of an issued entry reaches zero, the block raises a completion pulse that carries the entry's identifier. A flush empties the whole ring.

Top module: `vload_iq`

## Requirements
- R1: After reset the block shows an empty state. `req_ready_o` is 1. `iss_valid_o`, `cmt_valid_o` and `done_o` are 0. `pend_cnt_o` and `infl_cnt_o` are 0.
- R2: `req_ready_o` is 0 exactly when pending plus in-flight entries equal DEPTH. It does not depend on `req_valid_i` or on the unit field. A request offered while `req_ready_o` is 0 leaves the counts unchanged.
- R3: A request is taken only when `req_valid_i` and `req_ready_o` are both 1 and `req_unit_i` carries the load-unit code 2'b01. A request with any other code leaves the counts unchanged.
- R4: An entry's byte total is `req_vl_i << req_sew_i`, where the size code 0/1/2/3 stands for 1/2/4/8-byte elements. When a stage moves onto an entry, its remaining output starts at that total.
- R5: A decrement pulse lowers the remaining count of its stage by the given amount. If the amount exceeds the remaining count, the count becomes zero and does not wrap.
- R6: The issue stage completes its entry in the cycle its remaining count becomes zero, and that includes a zero-length entry. The pending count then falls by one and the in-flight count rises by one. Entries are issued in accept order.
- R7: `done_o` is 1, with `done_id_o` set to the commit entry's identifier, in the cycle the commit remaining count becomes zero. This happens only if the entry has already been issued or is issued in that same cycle. The commit stage then moves to the next entry.
- R8: When a single entry is issued and committed in the same cycle, both counts end at zero.
- R9: `flush_i` empties the ring at the next edge. In the flush cycle it blocks any accept and any completion pulse. The next accepted entry then becomes the issue and commit entry.
- R10: The positions wrap modulo DEPTH, so accept order is kept across more than DEPTH instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Empty the ring |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Ring has a free entry |
| req_unit_i | input | 2 | Target unit code (2'b01 = load) |
| req_vl_i | input | VL_W | Element count |
| req_sew_i | input | 2 | Element size code |
| req_id_i | input | ID_W | Instruction identifier |
| iss_dec_valid_i | input | 1 | Bytes-issued pulse |
| iss_dec_bytes_i | input | VL_W+3 | Bytes issued this cycle |
| cmt_dec_valid_i | input | 1 | Bytes-committed pulse |
| cmt_dec_bytes_i | input | VL_W+3 | Bytes committed this cycle |
| iss_valid_o | output | 1 | An entry waits to be issued |
| iss_id_o | output | ID_W | Identifier of the issue entry |
| iss_left_o | output | VL_W+3 | Bytes left to issue |
| cmt_valid_o | output | 1 | An entry waits to be committed |
| cmt_id_o | output | ID_W | Identifier of the commit entry |
| cmt_left_o | output | VL_W+3 | Bytes left to commit |
| pend_cnt_o | output | $clog2(DEPTH+1) | Accepted, not yet issued |
| infl_cnt_o | output | $clog2(DEPTH+1) | Issued, not yet committed |
| done_o | output | 1 | Completion pulse |
| done_id_o | output | ID_W | Identifier of the completed entry |

## Verification
The bench builds the block with DEPTH = 3, VL_W = 6 and ID_W = 4. A depth of three reaches the full state after three accepts. It also selects the compare-and-reset wrap variant, which the power-of-two variant would skip, and the accept position wraps twice within a short run. A 6-bit element count with size codes up to 3 keeps the byte totals small enough that an oversized decrement hits the saturation path. The same settings cover zero-length entries, commit bytes arriving before issue completes, and a flush that lands on a cycle where an issue and a commit would both complete.

// File: rtl/vload_iq_pkg.sv
package vload_iq_pkg;

   typedef enum logic [1:0] {
      UNIT_ALU   = 2'd0,
      UNIT_LOAD  = 2'd1,
      UNIT_STORE = 2'd2,
      UNIT_SLIDE = 2'd3
   } unit_e;

endpackage

// File: rtl/vload_iq_wrap.sv
module vload_iq_wrap #(
   parameter int DEPTH = 4,
   parameter int PTR_W = 2
) (
   input  logic [PTR_W-1:0] ptr_i,
   output logic [PTR_W-1:0] ptr_o
);
   localparam bit IS_POW2 = ((1 << PTR_W) == DEPTH);

   generate
      if (IS_POW2) begin : g_natural
         assign ptr_o = ptr_i + 1'b1;
      end else begin : g_compare
         assign ptr_o = (ptr_i == PTR_W'(DEPTH - 1)) ? '0 : ptr_i + 1'b1;
      end
   endgenerate
endmodule

// File: rtl/vload_iq_store.sv
module vload_iq_store #(
   parameter int DEPTH   = 4,
   parameter int ID_W    = 4,
   parameter int BYTES_W = 11,
   parameter int PTR_W   = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               flush_i,
   input  logic               wr_en_i,
   input  logic [ID_W-1:0]    wr_id_i,
   input  logic [BYTES_W-1:0] wr_bytes_i,
   output logic [PTR_W-1:0]   acc_ptr_o,
   input  logic [PTR_W-1:0]   rd_a_ptr_i,
   output logic [ID_W-1:0]    rd_a_id_o,
   output logic [BYTES_W-1:0] rd_a_bytes_o,
   input  logic [PTR_W-1:0]   rd_b_ptr_i,
   output logic [ID_W-1:0]    rd_b_id_o,
   output logic [BYTES_W-1:0] rd_b_bytes_o
);
   typedef struct packed {
      logic [ID_W-1:0]    id;
      logic [BYTES_W-1:0] bytes;
   } slot_t;

   slot_t              slot_q [DEPTH];
   logic [PTR_W-1:0]   acc_q, acc_inc;

   vload_iq_wrap #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_acc_wrap (
      .ptr_i (acc_q),
      .ptr_o (acc_inc)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q <= '0;
      end else if (flush_i) begin
         acc_q <= '0;
      end else if (wr_en_i) begin
         acc_q <= acc_inc;
      end
   end

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_slot
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               slot_q[s] <= '0;
            end else if (wr_en_i && !flush_i && (acc_q == PTR_W'(s))) begin
               slot_q[s] <= '{id: wr_id_i, bytes: wr_bytes_i};
            end
         end
      end
   endgenerate

   assign acc_ptr_o    = acc_q;
   assign rd_a_id_o    = slot_q[rd_a_ptr_i].id;
   assign rd_a_bytes_o = slot_q[rd_a_ptr_i].bytes;
   assign rd_b_id_o    = slot_q[rd_b_ptr_i].id;
   assign rd_b_bytes_o = slot_q[rd_b_ptr_i].bytes;
endmodule

// File: rtl/vload_iq_stage.sv
module vload_iq_stage #(
   parameter int DEPTH   = 4,
   parameter int BYTES_W = 11,
   parameter int PTR_W   = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               flush_i,
   input  logic               valid_i,
   input  logic [BYTES_W-1:0] entry_bytes_i,
   input  logic               dec_valid_i,
   input  logic [BYTES_W-1:0] dec_bytes_i,
   input  logic               allow_i,
   output logic [PTR_W-1:0]   ptr_o,
   output logic [BYTES_W-1:0] left_o,
   output logic               fire_o
);
   logic [BYTES_W-1:0] left_q, cur, nxt;
   logic               ld_q;
   logic [PTR_W-1:0]   ptr_q, ptr_inc;

   vload_iq_wrap #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_wrap (
      .ptr_i (ptr_q),
      .ptr_o (ptr_inc)
   );

   always_comb begin
      cur = ld_q ? left_q : entry_bytes_i;
      nxt = cur;
      if (dec_valid_i) begin
         nxt = (dec_bytes_i >= cur) ? '0 : cur - dec_bytes_i;
      end
   end

   assign fire_o = valid_i && allow_i && (nxt == '0);
   assign left_o = cur;
   assign ptr_o  = ptr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ptr_q  <= '0;
         ld_q   <= 1'b0;
         left_q <= '0;
      end else if (flush_i) begin
         ptr_q  <= '0;
         ld_q   <= 1'b0;
         left_q <= '0;
      end else if (fire_o) begin
         ptr_q  <= ptr_inc;
         ld_q   <= 1'b0;
      end else if (valid_i) begin
         left_q <= nxt;
         ld_q   <= 1'b1;
      end
   end

   AST_LEFT_NONINC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ld_q && $past(ld_q) && $stable(ptr_q)) |-> (left_q <= $past(left_q))); // R5
endmodule

// File: rtl/vload_iq.sv
module vload_iq
   import vload_iq_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int VL_W  = 8,
   parameter int ID_W  = 4,
   localparam int BYTES_W = VL_W + 3,
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               flush_i,
   input  logic               req_valid_i,
   output logic               req_ready_o,
   input  logic [1:0]         req_unit_i,
   input  logic [VL_W-1:0]    req_vl_i,
   input  logic [1:0]         req_sew_i,
   input  logic [ID_W-1:0]    req_id_i,
   input  logic               iss_dec_valid_i,
   input  logic [BYTES_W-1:0] iss_dec_bytes_i,
   input  logic               cmt_dec_valid_i,
   input  logic [BYTES_W-1:0] cmt_dec_bytes_i,
   output logic               iss_valid_o,
   output logic [ID_W-1:0]    iss_id_o,
   output logic [BYTES_W-1:0] iss_left_o,
   output logic               cmt_valid_o,
   output logic [ID_W-1:0]    cmt_id_o,
   output logic [BYTES_W-1:0] cmt_left_o,
   output logic [CNT_W-1:0]   pend_cnt_o,
   output logic [CNT_W-1:0]   infl_cnt_o,
   output logic               done_o,
   output logic [ID_W-1:0]    done_id_o
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("vload_iq: DEPTH must be at least 2");
      end
      if (VL_W < 1) begin : g_bad_vl
         $error("vload_iq: VL_W must be at least 1");
      end
      if (ID_W < 1) begin : g_bad_id
         $error("vload_iq: ID_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0]   pend_q, infl_q, total;
   logic               acc_fire, iss_fire, cmt_fire, cmt_allow;
   logic [PTR_W-1:0]   acc_ptr, iss_ptr, cmt_ptr;
   logic [BYTES_W-1:0] req_bytes, iss_entry_bytes, cmt_entry_bytes;

   assign total       = pend_q + infl_q;
   assign req_ready_o = (total != CNT_W'(DEPTH));
   assign acc_fire    = req_valid_i && req_ready_o && !flush_i && (req_unit_i == UNIT_LOAD);
   assign req_bytes   = BYTES_W'(req_vl_i) << req_sew_i;

   vload_iq_store #(.DEPTH(DEPTH), .ID_W(ID_W), .BYTES_W(BYTES_W), .PTR_W(PTR_W)) u_store (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .flush_i      (flush_i),
      .wr_en_i      (acc_fire),
      .wr_id_i      (req_id_i),
      .wr_bytes_i   (req_bytes),
      .acc_ptr_o    (acc_ptr),
      .rd_a_ptr_i   (iss_ptr),
      .rd_a_id_o    (iss_id_o),
      .rd_a_bytes_o (iss_entry_bytes),
      .rd_b_ptr_i   (cmt_ptr),
      .rd_b_id_o    (cmt_id_o),
      .rd_b_bytes_o (cmt_entry_bytes)
   );

   vload_iq_stage #(.DEPTH(DEPTH), .BYTES_W(BYTES_W), .PTR_W(PTR_W)) u_iss (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .flush_i       (flush_i),
      .valid_i       (iss_valid_o),
      .entry_bytes_i (iss_entry_bytes),
      .dec_valid_i   (iss_dec_valid_i),
      .dec_bytes_i   (iss_dec_bytes_i),
      .allow_i       (1'b1),
      .ptr_o         (iss_ptr),
      .left_o        (iss_left_o),
      .fire_o        (iss_fire)
   );

   // The oldest entry may finish only once issued, or issued in this very cycle.
   assign cmt_allow = (infl_q != '0) || iss_fire;

   vload_iq_stage #(.DEPTH(DEPTH), .BYTES_W(BYTES_W), .PTR_W(PTR_W)) u_cmt (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .flush_i       (flush_i),
      .valid_i       (cmt_valid_o),
      .entry_bytes_i (cmt_entry_bytes),
      .dec_valid_i   (cmt_dec_valid_i),
      .dec_bytes_i   (cmt_dec_bytes_i),
      .allow_i       (cmt_allow),
      .ptr_o         (cmt_ptr),
      .left_o        (cmt_left_o),
      .fire_o        (cmt_fire)
   );

   assign iss_valid_o = (pend_q != '0);
   assign cmt_valid_o = (total != '0);
   assign done_o      = cmt_fire && !flush_i;
   assign done_id_o   = cmt_id_o;
   assign pend_cnt_o  = pend_q;
   assign infl_cnt_o  = infl_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= '0;
         infl_q <= '0;
      end else if (flush_i) begin
         pend_q <= '0;
         infl_q <= '0;
      end else begin
         pend_q <= pend_q + CNT_W'(acc_fire) - CNT_W'(iss_fire);
         infl_q <= infl_q + CNT_W'(iss_fire) - CNT_W'(cmt_fire);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (total <= CNT_W'(DEPTH))); // R2
   AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> (pend_q == '0 && infl_q == '0)); // R9
   AST_ISS_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q == '0) |-> (iss_ptr == acc_ptr)); // R6
   AST_CMT_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (infl_q == '0) |-> (cmt_ptr == iss_ptr)); // R7
   AST_DONE_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> (total <= $past(total))); // R8
endmodule

// File: tb/vload_iq_tb_top.sv
module vload_iq_tb_top;
   localparam int DEPTH = 3;
   localparam int VL_W  = 6;
   localparam int ID_W  = 4;
   localparam int BW    = VL_W + 3;
   localparam int CW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_ni = 1'b0;
   logic          flush_i = 1'b0;
   logic          req_valid_i = 1'b0;
   logic          req_ready_o;
   logic [1:0]    req_unit_i = '0;
   logic [VL_W-1:0] req_vl_i = '0;
   logic [1:0]    req_sew_i = '0;
   logic [ID_W-1:0] req_id_i = '0;
   logic          iss_dec_valid_i = 1'b0;
   logic [BW-1:0] iss_dec_bytes_i = '0;
   logic          cmt_dec_valid_i = 1'b0;
   logic [BW-1:0] cmt_dec_bytes_i = '0;
   logic          iss_valid_o, cmt_valid_o, done_o;
   logic [ID_W-1:0] iss_id_o, cmt_id_o, done_id_o;
   logic [BW-1:0] iss_left_o, cmt_left_o;
   logic [CW-1:0] pend_cnt_o, infl_cnt_o;

   int n_cmp = 0;
   int n_bad = 0;
   int exp_q[$];

   always #4 clk = ~clk;

   vload_iq #(.DEPTH(DEPTH), .VL_W(VL_W), .ID_W(ID_W)) dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
      .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_unit_i(req_unit_i),
      .req_vl_i(req_vl_i), .req_sew_i(req_sew_i), .req_id_i(req_id_i),
      .iss_dec_valid_i(iss_dec_valid_i), .iss_dec_bytes_i(iss_dec_bytes_i),
      .cmt_dec_valid_i(cmt_dec_valid_i), .cmt_dec_bytes_i(cmt_dec_bytes_i),
      .iss_valid_o(iss_valid_o), .iss_id_o(iss_id_o), .iss_left_o(iss_left_o),
      .cmt_valid_o(cmt_valid_o), .cmt_id_o(cmt_id_o), .cmt_left_o(cmt_left_o),
      .pend_cnt_o(pend_cnt_o), .infl_cnt_o(infl_cnt_o),
      .done_o(done_o), .done_id_o(done_id_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic nxt();
      @(negedge clk);
      req_valid_i = 1'b0; flush_i = 1'b0;
      iss_dec_valid_i = 1'b0; cmt_dec_valid_i = 1'b0;
   endtask

   task automatic load(input int id, input int vl, input int sew, input bit expect_take);
      req_valid_i = 1'b1; req_unit_i = 2'b01;
      req_vl_i = VL_W'(vl); req_sew_i = 2'(sew); req_id_i = ID_W'(id);
      if (expect_take) exp_q.push_back(id);
   endtask

   task automatic iss(input int b);
      iss_dec_valid_i = 1'b1; iss_dec_bytes_i = BW'(b);
   endtask

   task automatic cmt(input int b);
      cmt_dec_valid_i = 1'b1; cmt_dec_bytes_i = BW'(b);
   endtask

   // Monitor: every completion pulse must match the oldest expected identifier.
   always begin
      @(negedge clk);
      #3;
      if (rst_ni && done_o) begin
         if (exp_q.size() == 0) begin
            chk("R7 unexpected completion", int'(done_id_o), -1);
         end else begin
            chk("R7 completion order", int'(done_id_o), exp_q.pop_front());
         end
      end
   end

   initial begin
      #(200000 * 8);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
      #2;
      chk("R1 ready", int'(req_ready_o), 1);
      chk("R1 iss_valid", int'(iss_valid_o), 0);
      chk("R1 cmt_valid", int'(cmt_valid_o), 0);
      chk("R1 pend", int'(pend_cnt_o), 0);
      chk("R1 infl", int'(infl_cnt_o), 0);
      chk("R1 done", int'(done_o), 0);

      nxt(); load(9, 5, 0, 1'b0); req_unit_i = 2'b10; #2;
      chk("R2 ready ignores unit", int'(req_ready_o), 1);
      nxt(); #2;
      chk("R3 other unit ignored pend", int'(pend_cnt_o), 0);
      chk("R3 other unit ignored valid", int'(iss_valid_o), 0);

      nxt(); load(1, 5, 0, 1'b1);
      nxt(); load(2, 3, 1, 1'b1);
      nxt(); load(3, 2, 3, 1'b1); #2;
      chk("R2 ready below full", int'(req_ready_o), 1);
      nxt(); load(14, 1, 0, 1'b0); #2;
      chk("R2 full ready", int'(req_ready_o), 0);
      chk("R2 full pend", int'(pend_cnt_o), 3);
      chk("R4 iss_left sew0", int'(iss_left_o), 5);
      chk("R6 iss_id first", int'(iss_id_o), 1);
      chk("R4 cmt_left", int'(cmt_left_o), 5);
      nxt(); #2;
      chk("R2 rejected when full", int'(pend_cnt_o), 3);

      nxt(); iss(3);
      nxt(); iss(7); #2;
      chk("R5 iss_left after dec", int'(iss_left_o), 2);
      nxt(); #2;
      chk("R5 saturate then R6 pend", int'(pend_cnt_o), 2);
      chk("R6 infl", int'(infl_cnt_o), 1);
      chk("R6 iss_id order", int'(iss_id_o), 2);
      chk("R4 iss_left sew1", int'(iss_left_o), 6);
      chk("R7 cmt_id oldest", int'(cmt_id_o), 1);

      nxt(); cmt(5); #2;
      chk("R7 done", int'(done_o), 1);
      chk("R7 done_id", int'(done_id_o), 1);
      nxt(); load(4, 0, 0, 1'b1); #2;
      chk("R2 ready after free", int'(req_ready_o), 1);
      chk("R7 infl after done", int'(infl_cnt_o), 0);
      chk("R7 cmt moved", int'(cmt_id_o), 2);
      chk("R7 cmt_left", int'(cmt_left_o), 6);
      chk("R7 no done yet", int'(done_o), 0);
      nxt(); cmt(6); #2;
      chk("R7 unissued entry holds", int'(done_o), 0);
      nxt(); iss(6); #2;
      chk("R7 done when issue completes", int'(done_o), 1);
      chk("R7 done_id same cycle", int'(done_id_o), 2);
      nxt(); #2;
      chk("R6 pend", int'(pend_cnt_o), 2);
      chk("R7 infl", int'(infl_cnt_o), 0);
      chk("R6 iss_id third", int'(iss_id_o), 3);
      chk("R4 iss_left sew3", int'(iss_left_o), 16);

      nxt(); iss(16);
      nxt(); #2;
      chk("R6 zero-length iss_id", int'(iss_id_o), 4);
      chk("R6 zero-length left", int'(iss_left_o), 0);
      chk("R6 pend mid", int'(pend_cnt_o), 1);
      nxt(); #2;
      chk("R6 zero-length issued pend", int'(pend_cnt_o), 0);
      chk("R6 zero-length infl", int'(infl_cnt_o), 2);
      chk("R6 iss_valid low", int'(iss_valid_o), 0);

      nxt(); cmt(10);
      nxt(); cmt(10); #2;
      chk("R5 commit saturates done", int'(done_o), 1);
      chk("R5 done_id", int'(done_id_o), 3);
      nxt(); #2;
      chk("R7 zero-length done", int'(done_o), 1);
      chk("R7 zero-length id", int'(done_id_o), 4);
      nxt(); #2;
      chk("R7 drained infl", int'(infl_cnt_o), 0);
      chk("R7 drained cmt_valid", int'(cmt_valid_o), 0);

      nxt(); load(5, 4, 0, 1'b1);
      nxt(); iss(4); cmt(4); #2;
      chk("R10 wrapped iss_id", int'(iss_id_o), 5);
      chk("R8 same-cycle done", int'(done_o), 1);
      chk("R8 same-cycle id", int'(done_id_o), 5);
      nxt(); #2;
      chk("R8 pend", int'(pend_cnt_o), 0);
      chk("R8 infl", int'(infl_cnt_o), 0);
      chk("R8 cmt_valid", int'(cmt_valid_o), 0);

      nxt(); load(6, 2, 2, 1'b1);
      nxt(); load(7, 1, 0, 1'b1);
      nxt(); #0;
      chk("R10 iss_id after wrap", int'(iss_id_o), 6);
      chk("R10 cmt_id after wrap", int'(cmt_id_o), 6);
      flush_i = 1'b1; load(8, 2, 0, 1'b0); iss(8); cmt(8);
      exp_q.delete();
      #2;
      chk("R9 done blocked", int'(done_o), 0);
      nxt(); #2;
      chk("R9 pend", int'(pend_cnt_o), 0);
      chk("R9 infl", int'(infl_cnt_o), 0);
      chk("R9 iss_valid", int'(iss_valid_o), 0);
      chk("R9 cmt_valid", int'(cmt_valid_o), 0);
      chk("R9 ready", int'(req_ready_o), 1);
      nxt(); load(9, 3, 1, 1'b1);
      nxt(); #2;
      chk("R9 restart iss_id", int'(iss_id_o), 9);
      chk("R9 restart iss_left", int'(iss_left_o), 6);
      chk("R9 restart cmt_id", int'(cmt_id_o), 9);
      chk("R9 restart pend", int'(pend_cnt_o), 1);
      nxt(); iss(6); cmt(6);
      nxt(); #2;
      chk("R7 all completions seen", exp_q.size(), 0);
      chk("R8 final infl", int'(infl_cnt_o), 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule